// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a tree of descriptors held in memory, and the tree has three levels. A requester hands it one address at a time through a valid/ready pair, with a flag that says whether the access is a write. The walker then reads descriptors through a request/acknowledge read port. The first read uses the table base held in the root pointer input. When the walk ends, the walker returns one response. The response carries the physical address, a fault flag and a 3-bit cause code.

The top level has 8-byte entries: a word of attributes followed by a word that holds the next base. The two lower levels use single-word entries. A 2-bit type field in every attribute word decides what happens next: the walk stops, it descends a level, or it ends on a page. A page can end the walk at any level. The low virtual-address bits that have not been translated at that point are added to the page base. After a walk that succeeds, the walker writes the page entry back through a second request/acknowledge port. The written entry has the used bit set, and for a write access the modified bit is set as well. The write-back is skipped when those bits are already set.

Top module: `tree_walker`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, rd_req and wr_req are 0.
- R2: The virtual address splits into fields from the top bit down: level-A index in bits 31:25, level-B index in bits 24:19, level-C index in bits 18:13, page offset in bits 12:0. The level-A entry is read as two words, first at root_tbl*16 + indexA*8 and then at that address + 4.
- R3: For a level-B or level-C entry, the walker reads the word at next_base + index*4. Here next_base is bits 31:4 of the previous table pointer word, with bits 3:0 zero. When a level-C page entry (type 1) ends the walk, PA = {entry[31:8], 8'h00} + va[12:0].
- R4: The type field is bits 1:0 of the attribute word: 0 is invalid, 1 is a page, 2 is a short table, 3 is a long table. At level A, type 2 and type 3 both descend to level B.
- R5: A type-1 entry at level A ends the walk after the second level-A word is read. PA = {word2[31:8], 8'h00} + va[24:0], and no level-B read is made.
- R6: A type-0 entry ends the walk with rsp_fault = 1, rsp_pa = 0 and no write-back. The cause is 1, 2 or 3 for level A, B or C.
- R7: A type-2 or type-3 entry at level C ends the walk with fault cause 5 and no write-back.
- R8: A write access ends with fault cause 4 and no write-back when bit 2 (write protect) is set in any attribute word on its path. A read access on the same path is translated normally.
- R9: A successful walk writes the page entry back at its own address, with bit 3 (used) set and, for a write access, bit 4 (modified) set. All other bits are kept. No write is made when those bits are already set.
- R10: Only one translation is in flight. req_ready drops in the cycle after a request is accepted and stays low until the response cycle has passed. rsp_valid lasts exactly one cycle.
- R11: A type-1 entry at level B ends the walk with PA = {entry[31:8], 8'h00} + va[18:0], and no level-C read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access |
| root_tbl | input | 28 | Level-A table base, bits 31:4; held stable during a walk |
| rd_req | output | 1 | Descriptor read request, held until acknowledged |
| rd_addr | output | 32 | Descriptor read byte address |
| rd_ack | input | 1 | Read data valid; completes the read |
| rd_data | input | 32 | Descriptor word read |
| wr_req | output | 1 | Page entry write-back request, held until acknowledged |
| wr_addr | output | 32 | Write-back byte address |
| wr_data | output | 32 | Updated page entry word |
| wr_ack | input | 1 | Write-back done |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Walk failed |
| rsp_cause | output | 3 | 0 none, 1/2/3 invalid at A/B/C, 4 write protect, 5 table type at level C |

## Verification
The hardest case to reach from the ports is a write-protect bit that appears on an intermediate level only. The page entry itself is clean, so the fault must come from state carried across reads. The stimulus builds a path whose long top-level entry points to a protected level-B table entry. It sends a write, which must fault with no write-back, and then a read of the same address, which must translate and mark the entry used. Early page termination at levels A and B is reached by placing type-1 entries in those tables. The log of read addresses shows that the walk stopped there.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned BIT_WP   = 2;
   localparam int unsigned BIT_USED = 3;
   localparam int unsigned BIT_MOD  = 4;

   typedef enum logic [1:0] {
      DT_INVALID = 2'd0,
      DT_PAGE    = 2'd1,
      DT_SHORT   = 2'd2,
      DT_LONG    = 2'd3
   } desc_type_e;

   typedef enum logic [2:0] {
      CZ_NONE  = 3'd0,
      CZ_INV_A = 3'd1,
      CZ_INV_B = 3'd2,
      CZ_INV_C = 3'd3,
      CZ_PROT  = 3'd4,
      CZ_BAD_C = 3'd5
   } cause_e;

   typedef enum logic [2:0] {
      S_IDLE, S_RA0, S_RA1, S_RB, S_RC, S_WR, S_RSP
   } walk_state_e;

   // Sets the used bit, and the modified bit for a write.
   function automatic logic [WORD_W-1:0] mark_word(input logic [WORD_W-1:0] w,
                                                   input logic is_wr);
      logic [WORD_W-1:0] r;
      r = w;
      r[BIT_USED] = 1'b1;
      if (is_wr) r[BIT_MOD] = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/tw_va_split.sv
module tw_va_split #(
   parameter int unsigned IA_W  = 7,
   parameter int unsigned IB_W  = 6,
   parameter int unsigned IC_W  = 6,
   parameter int unsigned OFF_W = 13,
   localparam int unsigned VA_W   = IA_W + IB_W + IC_W + OFF_W,
   localparam int unsigned REMA_W = IB_W + IC_W + OFF_W,
   localparam int unsigned REMB_W = IC_W + OFF_W
) (
   input  logic [VA_W-1:0]   va,
   output logic [IA_W-1:0]   idx_a,
   output logic [IB_W-1:0]   idx_b,
   output logic [IC_W-1:0]   idx_c,
   output logic [REMA_W-1:0] rem_a,
   output logic [REMB_W-1:0] rem_b,
   output logic [OFF_W-1:0]  off
);
   initial begin
      a_r2_field_sum: assert (VA_W == tw_pkg::WORD_W)
         else $fatal(1, "index and offset widths must sum to the word width");
      a_r2_nonzero: assert (IA_W > 0 && IB_W > 0 && IC_W > 0 && OFF_W >= 8)
         else $fatal(1, "field widths out of range");
   end

   assign idx_a = va[VA_W-1 -: IA_W];
   assign idx_b = va[REMB_W +: IB_W];
   assign idx_c = va[OFF_W +: IC_W];
   assign rem_a = va[REMA_W-1:0];
   assign rem_b = va[REMB_W-1:0];
   assign off   = va[OFF_W-1:0];
endmodule

// File: rtl/tw_desc_decode.sv
module tw_desc_decode
   import tw_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output desc_type_e        dtype,
   output logic              wp,
   output logic              used,
   output logic              modified,
   output logic [WORD_W-1:0] tbl_base,
   output logic [WORD_W-1:0] pg_base
);
   assign dtype    = desc_type_e'(word[1:0]);
   assign wp       = word[BIT_WP];
   assign used     = word[BIT_USED];
   assign modified = word[BIT_MOD];
   assign tbl_base = {word[WORD_W-1:4], 4'h0};
   assign pg_base  = {word[WORD_W-1:8], 8'h00};
endmodule

// File: rtl/tw_walk_fsm.sv
module tw_walk_fsm
   import tw_pkg::*;
#(
   parameter int unsigned IA_W  = 7,
   parameter int unsigned IB_W  = 6,
   parameter int unsigned IC_W  = 6,
   parameter int unsigned OFF_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [WORD_W-1:0] req_va,
   input  logic              req_write,
   input  logic [WORD_W-1:4] root_tbl,
   output logic              rd_req,
   output logic [WORD_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [WORD_W-1:0] rd_data,
   input  desc_type_e        dec_type,
   input  logic              dec_wp,
   input  logic              dec_used,
   input  logic              dec_mod,
   input  logic [WORD_W-1:0] dec_tbl,
   input  logic [WORD_W-1:0] dec_pg,
   output logic              wr_req,
   output logic [WORD_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   input  logic              wr_ack,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_pa,
   output logic              rsp_fault,
   output logic [2:0]        rsp_cause
);
   localparam int unsigned REMA_W = IB_W + IC_W + OFF_W;
   localparam int unsigned REMB_W = IC_W + OFF_W;

   walk_state_e       state;
   logic [WORD_W-1:0] va_q, attr_q, pte_addr_q, tbl_q, pa_q, wb_addr_q, wb_data_q;
   logic              wr_q, wp_acc;
   desc_type_e        dt_a_q;
   cause_e            cause_q;

   logic [IA_W-1:0]   idx_a;
   logic [IB_W-1:0]   idx_b;
   logic [IC_W-1:0]   idx_c;
   logic [REMA_W-1:0] rem_a;
   logic [REMB_W-1:0] rem_b;
   logic [OFF_W-1:0]  off;

   tw_va_split #(.IA_W(IA_W), .IB_W(IB_W), .IC_W(IC_W), .OFF_W(OFF_W)) u_split (
      .va(va_q), .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
      .rem_a(rem_a), .rem_b(rem_b), .off(off)
   );

   // Descriptor addresses
   logic [WORD_W-1:0] a_addr;
   assign a_addr = {root_tbl, 4'h0} + {{(WORD_W-IA_W-3){1'b0}}, idx_a, 3'b000};

   always_comb begin
      unique case (state)
         S_RA0:   rd_addr = a_addr;
         S_RA1:   rd_addr = a_addr + WORD_W'(4);
         S_RB:    rd_addr = tbl_q + {{(WORD_W-IB_W-2){1'b0}}, idx_b, 2'b00};
         S_RC:    rd_addr = tbl_q + {{(WORD_W-IC_W-2){1'b0}}, idx_c, 2'b00};
         default: rd_addr = '0;
      endcase
   end

   // Outcome of the descriptor being acknowledged this cycle
   logic              end_page, end_fault, wp_now, pg_used, pg_mod, prot, need_wb;
   cause_e            f_cause;
   logic [WORD_W-1:0] pg_word, pg_addr, pg_pa;

   always_comb begin
      end_page  = 1'b0;
      end_fault = 1'b0;
      f_cause   = CZ_NONE;
      pg_word   = rd_data;
      pg_addr   = rd_addr;
      pg_used   = dec_used;
      pg_mod    = dec_mod;
      pg_pa     = '0;
      wp_now    = wp_acc | dec_wp;
      unique case (state)
         S_RA0: if (dec_type == DT_INVALID) begin
            end_fault = 1'b1;
            f_cause   = CZ_INV_A;
         end
         S_RA1: begin
            wp_now = wp_acc;
            if (dt_a_q == DT_PAGE) begin
               end_page = 1'b1;
               pg_word  = attr_q;
               pg_addr  = pte_addr_q;
               pg_used  = attr_q[BIT_USED];
               pg_mod   = attr_q[BIT_MOD];
               pg_pa    = dec_pg + {{(WORD_W-REMA_W){1'b0}}, rem_a};
            end
         end
         S_RB: if (dec_type == DT_INVALID) begin
            end_fault = 1'b1;
            f_cause   = CZ_INV_B;
         end else if (dec_type == DT_PAGE) begin
            end_page = 1'b1;
            pg_pa    = dec_pg + {{(WORD_W-REMB_W){1'b0}}, rem_b};
         end
         S_RC: if (dec_type == DT_INVALID) begin
            end_fault = 1'b1;
            f_cause   = CZ_INV_C;
         end else if (dec_type == DT_PAGE) begin
            end_page = 1'b1;
            pg_pa    = dec_pg + {{(WORD_W-OFF_W){1'b0}}, off};
         end else begin
            end_fault = 1'b1;
            f_cause   = CZ_BAD_C;
         end
         default: ;
      endcase
      prot    = wr_q & wp_now;
      need_wb = !pg_used || (wr_q && !pg_mod);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         va_q       <= '0;
         wr_q       <= 1'b0;
         wp_acc     <= 1'b0;
         attr_q     <= '0;
         dt_a_q     <= DT_INVALID;
         pte_addr_q <= '0;
         tbl_q      <= '0;
         pa_q       <= '0;
         wb_addr_q  <= '0;
         wb_data_q  <= '0;
         cause_q    <= CZ_NONE;
      end else begin
         unique case (state)
            S_IDLE: if (req_valid) begin
               va_q   <= req_va;
               wr_q   <= req_write;
               wp_acc <= 1'b0;
               state  <= S_RA0;
            end
            S_RA0, S_RA1, S_RB, S_RC: if (rd_ack) begin
               if (end_fault) begin
                  cause_q <= f_cause;
                  pa_q    <= '0;
                  state   <= S_RSP;
               end else if (end_page) begin
                  if (prot) begin
                     cause_q <= CZ_PROT;
                     pa_q    <= '0;
                     state   <= S_RSP;
                  end else begin
                     cause_q   <= CZ_NONE;
                     pa_q      <= pg_pa;
                     wb_addr_q <= pg_addr;
                     wb_data_q <= mark_word(pg_word, wr_q);
                     state     <= need_wb ? S_WR : S_RSP;
                  end
               end else begin
                  wp_acc <= wp_now;
                  unique case (state)
                     S_RA0: begin
                        attr_q     <= rd_data;
                        dt_a_q     <= dec_type;
                        pte_addr_q <= rd_addr;
                        state      <= S_RA1;
                     end
                     S_RA1:   begin tbl_q <= dec_tbl; state <= S_RB; end
                     default: begin tbl_q <= dec_tbl; state <= S_RC; end
                  endcase
               end
            end
            S_WR:  if (wr_ack) state <= S_RSP;
            S_RSP: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign req_ready = (state == S_IDLE);
   assign rd_req    = (state == S_RA0) || (state == S_RA1) || (state == S_RB) || (state == S_RC);
   assign wr_req    = (state == S_WR);
   assign wr_addr   = wb_addr_q;
   assign wr_data   = wb_data_q;
   assign rsp_valid = (state == S_RSP);
   assign rsp_pa    = pa_q;
   assign rsp_fault = (cause_q != CZ_NONE);
   assign rsp_cause = cause_q;

   a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   a_r10_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));
   a_r6_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0));
   a_r9_used_written: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> wr_data[BIT_USED]);
   a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
   a_r10_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req) && !(rd_req && req_ready));
endmodule

// File: rtl/tree_walker.sv
module tree_walker
   import tw_pkg::*;
#(
   parameter int unsigned IA_W  = 7,
   parameter int unsigned IB_W  = 6,
   parameter int unsigned IC_W  = 6,
   parameter int unsigned OFF_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_va,
   input  logic              req_write,
   input  logic [31:4]       root_tbl,
   output logic              rd_req,
   output logic [31:0]       rd_addr,
   input  logic              rd_ack,
   input  logic [31:0]       rd_data,
   output logic              wr_req,
   output logic [31:0]       wr_addr,
   output logic [31:0]       wr_data,
   input  logic              wr_ack,
   output logic              rsp_valid,
   output logic [31:0]       rsp_pa,
   output logic              rsp_fault,
   output logic [2:0]        rsp_cause
);
   desc_type_e        dec_type;
   logic              dec_wp, dec_used, dec_mod;
   logic [WORD_W-1:0] dec_tbl, dec_pg;

   tw_desc_decode u_dec (
      .word(rd_data), .dtype(dec_type), .wp(dec_wp), .used(dec_used),
      .modified(dec_mod), .tbl_base(dec_tbl), .pg_base(dec_pg)
   );

   tw_walk_fsm #(.IA_W(IA_W), .IB_W(IB_W), .IC_W(IC_W), .OFF_W(OFF_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
      .root_tbl(root_tbl),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .dec_type(dec_type), .dec_wp(dec_wp), .dec_used(dec_used), .dec_mod(dec_mod),
      .dec_tbl(dec_tbl), .dec_pg(dec_pg),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
   );
endmodule

// File: tb/tree_walker_test.sv
module tree_walker_test;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [31:0] ROOT = 32'h0001_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_va = '0;
   logic req_ready, rd_req, wr_req, rsp_valid, rsp_fault;
   logic [31:0] rd_addr, wr_addr, wr_data, rsp_pa;
   logic [2:0]  rsp_cause;
   logic rd_ack = 1'b0, wr_ack = 1'b0;
   logic [31:0] rd_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tree_walker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_write(req_write), .root_tbl(ROOT[31:4]),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
   );

   int n_vec = 0, n_bad = 0, n_done = 0, ready_viol = 0;
   logic busy = 1'b0;

   logic [31:0] mem [logic [31:0]];
   logic [31:0] rd_log[$];
   logic [31:0] wa_log[$];
   logic [31:0] wd_log[$];

   typedef struct packed {
      logic [31:0]      pa;
      logic [2:0]       cause;
      logic             wb;
      logic [31:0]      wba;
      logic [31:0]      wbd;
      logic [2:0]       nrd;
      logic [3:0][31:0] rds;
   } exp_t;
   exp_t  exp_q[$];
   string tag_q[$];

   function automatic logic [31:0] mkva(input int a, input int b, input int c, input int o);
      return {a[6:0], b[5:0], c[5:0], o[12:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Memory model: one-cycle acknowledge on both ports
   initial begin
      forever begin
         @(posedge clk);
         if (rd_req && !rd_ack) begin
            rd_data <= mem.exists(rd_addr) ? mem[rd_addr] : 32'h0;
            rd_log.push_back(rd_addr);
            rd_ack  <= 1'b1;
         end else rd_ack <= 1'b0;
         if (wr_req && !wr_ack) begin
            mem[wr_addr] = wr_data;
            wa_log.push_back(wr_addr);
            wd_log.push_back(wr_data);
            wr_ack <= 1'b1;
         end else wr_ack <= 1'b0;
      end
   end

   // Monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (busy && req_ready) ready_viol++;
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               n_vec++; n_bad++;
               $display("FAIL R10: actual extra response expected none");
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, rsp_pa, e.pa);
               chk(t, {31'h0, rsp_fault}, {31'h0, e.cause != 3'd0});
               chk(t, {29'h0, rsp_cause}, {29'h0, e.cause});
               chk({t, " write count"}, wa_log.size(), {31'h0, e.wb});
               if (e.wb && wa_log.size() == 1) begin
                  chk({t, " write addr"}, wa_log[0], e.wba);
                  chk({t, " write data"}, wd_log[0], e.wbd);
               end
               chk({"R2 ", t, " read count"}, rd_log.size(), {29'h0, e.nrd});
               for (int i = 0; i < int'(e.nrd) && i < rd_log.size(); i++)
                  chk({"R2 ", t, " read addr"}, rd_log[i], e.rds[i]);
               chk("R10 ready while busy", ready_viol, 0);
            end
            rd_log.delete(); wa_log.delete(); wd_log.delete();
            busy = 1'b0;
            n_done++;
         end
      end
   end

   task automatic walk(input string tag, input logic [31:0] va, input logic wr,
                       input logic [31:0] pa, input logic [2:0] cause,
                       input logic wb, input logic [31:0] wba, input logic [31:0] wbd,
                       input int nrd, input logic [31:0] r0, input logic [31:0] r1,
                       input logic [31:0] r2, input logic [31:0] r3);
      exp_t e;
      int   target;
      e.pa = pa; e.cause = cause; e.wb = wb; e.wba = wba; e.wbd = wbd;
      e.nrd = nrd[2:0]; e.rds = {r3, r2, r1, r0};
      exp_q.push_back(e);
      tag_q.push_back(tag);
      target = n_done + 1;
      @(negedge clk);
      chk("R10 ready when idle", {31'h0, req_ready}, 32'h1);
      req_va = va; req_write = wr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      busy = 1'b1;
      wait (n_done == target);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] va;
      // Level A 5: short table -> B at 0x20000; B 9 -> C at 0x30000; C 17 page
      mem[32'h0001_0028] = 32'h0000_0002;  mem[32'h0001_002C] = 32'h0002_0000;
      mem[32'h0002_0024] = 32'h0003_0002;
      mem[32'h0003_0044] = 32'h1234_5601;
      mem[32'h0003_004C] = 32'h0004_0002;
      // Level A 7: long table type, B 1 write-protected table, C 2 page
      mem[32'h0001_0038] = 32'h0000_0003;  mem[32'h0001_003C] = 32'h0005_0000;
      mem[32'h0005_0004] = 32'h0006_0006;
      mem[32'h0006_0008] = 32'h0AB0_0001;
      // Level A 8: page at level A
      mem[32'h0001_0040] = 32'h0000_0001;  mem[32'h0001_0044] = 32'h4000_0000;
      // Level A 9: table -> B 3 page
      mem[32'h0001_0048] = 32'h0000_0002;  mem[32'h0001_004C] = 32'h0007_0000;
      mem[32'h0007_000C] = 32'h0080_0001;
      // Level A 10: write-protected page at level A
      mem[32'h0001_0050] = 32'h0000_0005;  mem[32'h0001_0054] = 32'h5000_0000;

      repeat (3) @(negedge clk);
      chk("R1 ready", {31'h0, req_ready}, 32'h1);
      chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
      chk("R1 rd_req", {31'h0, rd_req}, 32'h0);
      chk("R1 wr_req", {31'h0, wr_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      va = mkva(5, 9, 17, 13'h0ABC);
      walk("R3 full walk read", va, 1'b0, 32'h1234_60BC, 3'd0, 1'b1, 32'h0003_0044, 32'h1234_5609,
           4, 32'h0001_0028, 32'h0001_002C, 32'h0002_0024, 32'h0003_0044);
      walk("R9 used already set", va, 1'b0, 32'h1234_60BC, 3'd0, 1'b0, 0, 0,
           4, 32'h0001_0028, 32'h0001_002C, 32'h0002_0024, 32'h0003_0044);
      walk("R9 write sets modified", va, 1'b1, 32'h1234_60BC, 3'd0, 1'b1, 32'h0003_0044, 32'h1234_5619,
           4, 32'h0001_0028, 32'h0001_002C, 32'h0002_0024, 32'h0003_0044);
      walk("R9 write no update", va, 1'b1, 32'h1234_60BC, 3'd0, 1'b0, 0, 0,
           4, 32'h0001_0028, 32'h0001_002C, 32'h0002_0024, 32'h0003_0044);
      walk("R6 invalid level A", mkva(6, 1, 1, 0), 1'b0, 0, 3'd1, 1'b0, 0, 0,
           1, 32'h0001_0030, 0, 0, 0);
      walk("R6 invalid level B", mkva(5, 10, 1, 0), 1'b0, 0, 3'd2, 1'b0, 0, 0,
           3, 32'h0001_0028, 32'h0001_002C, 32'h0002_0028, 0);
      walk("R6 invalid level C", mkva(5, 9, 18, 0), 1'b1, 0, 3'd3, 1'b0, 0, 0,
           4, 32'h0001_0028, 32'h0001_002C, 32'h0002_0024, 32'h0003_0048);
      walk("R7 table type at C", mkva(5, 9, 19, 0), 1'b0, 0, 3'd5, 1'b0, 0, 0,
           4, 32'h0001_0028, 32'h0001_002C, 32'h0002_0024, 32'h0003_004C);
      walk("R8 protect on B path", mkva(7, 1, 2, 13'h1F00), 1'b1, 0, 3'd4, 1'b0, 0, 0,
           4, 32'h0001_0038, 32'h0001_003C, 32'h0005_0004, 32'h0006_0008);
      walk("R4 long type descends", mkva(7, 1, 2, 13'h1F00), 1'b0, 32'h0AB0_1F00, 3'd0, 1'b1,
           32'h0006_0008, 32'h0AB0_0009,
           4, 32'h0001_0038, 32'h0001_003C, 32'h0005_0004, 32'h0006_0008);
      walk("R5 page at level A", {7'd8, 25'h0ABCDEF}, 1'b0, 32'h40AB_CDEF, 3'd0, 1'b1,
           32'h0001_0040, 32'h0000_0009, 2, 32'h0001_0040, 32'h0001_0044, 0, 0);
      walk("R11 page at level B", {7'd9, 6'd3, 19'h12345}, 1'b1, 32'h0081_2345, 3'd0, 1'b1,
           32'h0007_000C, 32'h0080_0019, 3, 32'h0001_0048, 32'h0001_004C, 32'h0007_000C, 0);
      walk("R8 protect at level A page", {7'd10, 25'h0000123}, 1'b1, 0, 3'd4, 1'b0, 0, 0,
           2, 32'h0001_0050, 32'h0001_0054, 0, 0);

      @(negedge clk);
      chk("R10 rsp_valid one cycle", {31'h0, rsp_valid}, 32'h0);
      chk("R10 idle after response", {31'h0, req_ready}, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule